// File: doc/BRIEF.md
# SPI Port Controller

A byte-wide serial peripheral interface engine that sits on a simple processor register port. One 8-bit control register chooses whether the block runs, whether it is the clock master or a slave, how the slave-select line is treated, the idle level and sampling edge of SCK, and a three-bit rate code that sets the master clock divisor. An 8-bit data register is the transmit byte on write and the received byte on read. A single done flag reports the end of each byte.

As master, a data write starts an MSB-first byte. The block drives SCK from a prescaler, drives MOSI, and pulls its select output low for the byte. As slave, it synchronises the external SCK and select inputs to the system clock, shifts MOSI in, and drives MISO only while selected. The register port has no back-pressure. Every access completes in the cycle it is presented. A data write that arrives while a byte is in flight is dropped. A control write in that window is held and applied once the byte ends. Software learns of completion by polling the done flag, which it clears by reading the data register.

Top module: `spi_port_top`

## Requirements
- R1: After reset the control register reads 0x14, SCK output is high with its enable low, ss_o is high and the done flag is low. Control bit layout: bit 7 rate code MSB, bit 6 enable, bit 5 select-ignore, bit 4 master, bit 3 CPOL, bit 2 CPHA, bits 1:0 rate code low bits. bus_sel_data = 0 addresses control, 1 addresses data.
- R2: While enable (bit 6) is 0, sck_o is high whatever CPOL is, and a data write produces no SCK edge and no done flag.
- R3: While enabled and no master byte is in flight, sck_o equals CPOL (bit 3).
- R4: The rate code {bit 7, bit 1, bit 0} sets the master SCK period to 2, 4, 8, 16, 32, 64 or 128 system clocks for codes 0 to 6, and code 7 gives 128. A byte holds SCK away from idle for exactly 8 half periods.
- R5: In master mode with enable set, a data write starts an 8-bit transfer with 16 SCK edges. Afterwards the data register holds the byte sampled on miso_i.
- R6: Bits leave MSB first. With CPHA (bit 2) = 0 a bit is sampled when SCK leaves idle and changes when it returns, and the first bit is valid before the first edge. With CPHA = 1 a bit changes when SCK leaves idle and is sampled when it returns. The same applies in both roles.
- R7: xfer_done rises when the eighth bit has been sampled and clears after the data register is read.
- R8: In master mode, ss_o is low during a byte when select-ignore (bit 5) is 0, and stays high when it is 1.
- R9: In slave mode with the select input honoured, ss_i high keeps the bit counter at zero, leaves the data register unchanged and keeps miso_oe low.
- R10: In slave mode, select-ignore = 1 makes ss_i irrelevant when CPHA = 1. When CPHA = 0, ss_i high still blocks the transfer.
- R11: A control write made while a byte is in flight leaves the control register unchanged until the byte completes, and is then applied.
- R12: A data write made while a master byte is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (reading data clears done) |
| bus_sel_data | input | 1 | 0 selects control, 1 selects data |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational from the selected register |
| xfer_done | output | 1 | Byte-complete flag |
| sck_o | output | 1 | Serial clock out |
| sck_oe | output | 1 | Serial clock drive enable (master) |
| sck_i | input | 1 | Serial clock in (slave) |
| mosi_o | output | 1 | Master data out |
| mosi_oe | output | 1 | Master data drive enable |
| mosi_i | input | 1 | Slave data in |
| miso_o | output | 1 | Slave data out |
| miso_oe | output | 1 | Slave data drive enable (selected only) |
| miso_i | input | 1 | Master data in |
| ss_o | output | 1 | Select output, active low |
| ss_i | input | 1 | Select input, active low |

## Verification
Several properties are checked on every cycle. The control register never moves while a byte is in flight. SCK rests at CPOL whenever the master generator is idle. A deselected slave's bit counter is forced to zero. The done flag only rises right after a sampling edge, and the select output is released outside a master byte. Other behaviour needs the bench's scenarios: the divisor for each rate code, MSB-first ordering and the edge on which each CPHA setting samples, the exact byte received, and the select-ignore exception for CPHA = 0. It also needs the stimulus that tries to disturb a byte with register writes. These come from measuring SCK, capturing MOSI and MISO at the sampling edges, and reading registers back.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int DATA_W = 8;
  localparam int RATE_W = 3;
  localparam int HALF_W = (1 << RATE_W) - 1;
  localparam logic [7:0] CTRL_RESET = 8'h14;

  // field order is the register's bit order, MSB first
  typedef struct packed {
    logic rate_hi;
    logic enable;
    logic ss_ignore;
    logic master;
    logic cpol;
    logic cpha;
    logic rate_mid;
    logic rate_lo;
  } ctrl_t;

  function automatic logic [RATE_W-1:0] rate_code(ctrl_t c);
    return {c.rate_hi, c.rate_mid, c.rate_lo};
  endfunction

  // half SCK period in system clocks; top code aliases the one below it
  function automatic logic [HALF_W-1:0] half_len(logic [RATE_W-1:0] code);
    logic [RATE_W-1:0] e;
    e = (code == '1) ? code - 1'b1 : code;
    return HALF_W'(1) << e;
  endfunction
endpackage

// File: rtl/spi_port_ctrl.sv
module spi_port_ctrl
  import spi_port_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_req,
  input  logic [7:0] wr_data,
  input  logic       busy,
  output ctrl_t      ctrl_q
);
  ctrl_t pend_q;
  logic  pend_v;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= ctrl_t'(CTRL_RESET);
      pend_q <= ctrl_t'(CTRL_RESET);
      pend_v <= 1'b0;
    end else if (wr_req) begin
      if (busy) begin
        pend_q <= ctrl_t'(wr_data);
        pend_v <= 1'b1;
      end else begin
        ctrl_q <= ctrl_t'(wr_data);
        pend_v <= 1'b0;
      end
    end else if (pend_v && !busy) begin
      ctrl_q <= pend_q;
      pend_v <= 1'b0;
    end
  end

  AST_CTRL_FROZEN: assert property (@(posedge clk) disable iff (!rst_n) busy && $past(busy) |-> $stable(ctrl_q)); // R11
endmodule

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen
  import spi_port_pkg::*;
#(
  parameter int DW = DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run_en,
  input  logic              start,
  input  logic [RATE_W-1:0] rate,
  output logic              busy,
  output logic              phase,
  output logic              lead,
  output logic              trail
);
  localparam int EDGES = 2 * DW;
  localparam int EW = $clog2(EDGES);
  localparam logic [EW-1:0] LAST_EDGE = EW'(EDGES - 1);

  logic [HALF_W-1:0] hcnt;
  logic [HALF_W-1:0] half;
  logic [EW-1:0]     ecnt;
  logic              tick;

  assign half = half_len(rate);
  assign tick = busy && (hcnt == half - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      phase <= 1'b0;
      hcnt  <= '0;
      ecnt  <= '0;
    end else if (!run_en) begin
      busy  <= 1'b0;
      phase <= 1'b0;
      hcnt  <= '0;
      ecnt  <= '0;
    end else if (start && !busy) begin
      busy  <= 1'b1;
      phase <= 1'b0;
      hcnt  <= '0;
      ecnt  <= '0;
    end else if (busy) begin
      if (tick) begin
        hcnt  <= '0;
        phase <= ~phase;
        ecnt  <= ecnt + 1'b1;
        if (ecnt == LAST_EDGE) busy <= 1'b0;
      end else begin
        hcnt <= hcnt + 1'b1;
      end
    end
  end

  assign lead  = tick & ~phase;
  assign trail = tick & phase;

  AST_PHASE_AT_REST: assert property (@(posedge clk) disable iff (!rst_n) !busy |-> !phase); // R3
endmodule

// File: rtl/spi_port_slvsync.sv
module spi_port_slvsync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sck_in,
  input  logic ss_in,
  input  logic cpol,
  output logic lead,
  output logic trail,
  output logic ss_level
);
  logic [STAGES-1:0] sck_sh;
  logic [STAGES-1:0] ss_sh;
  logic              sck_d;
  logic              rise;
  logic              fall;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_sh <= '0;
      ss_sh  <= '1;
      sck_d  <= 1'b0;
    end else begin
      sck_sh <= {sck_sh[STAGES-2:0], sck_in};
      ss_sh  <= {ss_sh[STAGES-2:0], ss_in};
      sck_d  <= sck_sh[STAGES-1];
    end
  end

  assign rise     = sck_sh[STAGES-1] & ~sck_d;
  assign fall     = ~sck_sh[STAGES-1] & sck_d;
  assign lead     = cpol ? fall : rise;
  assign trail    = cpol ? rise : fall;
  assign ss_level = ss_sh[STAGES-1];
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
  parameter int DW = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   clear,
  input  logic                   load,
  input  logic [DW-1:0]          load_val,
  input  logic                   launch,
  input  logic                   sample,
  input  logic                   ser_in,
  output logic [DW-1:0]          shreg,
  output logic                   ser_out,
  output logic [$clog2(DW)-1:0]  bit_cnt,
  output logic                   last_bit
);
  localparam int CW = $clog2(DW);
  localparam logic [CW-1:0] LAST = CW'(DW - 1);

  assign last_bit = sample && !load && !clear && (bit_cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shreg   <= '0;
      ser_out <= 1'b0;
      bit_cnt <= '0;
    end else if (load) begin
      shreg   <= load_val;
      ser_out <= load_val[DW-1];
      bit_cnt <= '0;
    end else if (clear) begin
      bit_cnt <= '0;
      ser_out <= shreg[DW-1];
    end else begin
      if (sample) begin
        shreg   <= {shreg[DW-2:0], ser_in};
        bit_cnt <= (bit_cnt == LAST) ? '0 : bit_cnt + 1'b1;
      end
      if (launch || bit_cnt == '0) ser_out <= shreg[DW-1];
    end
  end

  AST_CNT_HELD: assert property (@(posedge clk) disable iff (!rst_n) clear && !load |=> bit_cnt == '0); // R9
endmodule

// File: rtl/spi_port_top.sv
module spi_port_top
  import spi_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_sel_data,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              xfer_done,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sck_i,
  output logic              mosi_o,
  output logic              mosi_oe,
  input  logic              mosi_i,
  output logic              miso_o,
  output logic              miso_oe,
  input  logic              miso_i,
  output logic              ss_o,
  input  logic              ss_i
);
  localparam int CW = $clog2(DATA_W);

  ctrl_t             cfg;
  logic              m_busy, m_phase, m_lead, m_trail;
  logic              s_lead, s_trail, ss_lvl;
  logic [DATA_W-1:0] sh_reg;
  logic              ser_out, last_bit;
  logic [CW-1:0]     sh_cnt;
  logic              master_on, slave_on, slave_go;
  logic              ctrl_wr, data_wr, data_rd;
  logic              busy_all, load, start, clear;
  logic              ss_honour, selected;
  logic              launch, sample, ser_in;

  assign master_on = cfg.enable & cfg.master;
  assign slave_on  = cfg.enable & ~cfg.master;
  assign ctrl_wr   = bus_wr & ~bus_sel_data;
  assign data_wr   = bus_wr & bus_sel_data;
  assign data_rd   = bus_rd & bus_sel_data;
  assign busy_all  = m_busy | (sh_cnt != '0);
  assign load      = data_wr & ~busy_all;
  assign start     = load & master_on;

  // select-ignore only takes effect for the late-sampling phase in slave role
  assign ss_honour = ~cfg.ss_ignore | ~cfg.cpha;
  assign selected  = ~ss_honour | ~ss_lvl;
  assign slave_go  = slave_on & selected;
  assign clear     = ~cfg.enable | (~cfg.master & ~selected);

  assign launch = master_on ? (cfg.cpha ? m_lead : m_trail)
                            : (slave_go & (cfg.cpha ? s_lead : s_trail));
  assign sample = master_on ? (cfg.cpha ? m_trail : m_lead)
                            : (slave_go & (cfg.cpha ? s_trail : s_lead));
  assign ser_in = master_on ? miso_i : mosi_i;

  spi_port_ctrl u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_req  (ctrl_wr),
    .wr_data (bus_wdata),
    .busy    (busy_all),
    .ctrl_q  (cfg)
  );

  spi_port_clkgen #(.DW(DATA_W)) u_clkgen (
    .clk    (clk),
    .rst_n  (rst_n),
    .run_en (master_on),
    .start  (start),
    .rate   (rate_code(cfg)),
    .busy   (m_busy),
    .phase  (m_phase),
    .lead   (m_lead),
    .trail  (m_trail)
  );

  spi_port_slvsync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sck_in   (sck_i),
    .ss_in    (ss_i),
    .cpol     (cfg.cpol),
    .lead     (s_lead),
    .trail    (s_trail),
    .ss_level (ss_lvl)
  );

  spi_port_shifter #(.DW(DATA_W)) u_shift (
    .clk      (clk),
    .rst_n    (rst_n),
    .clear    (clear),
    .load     (load),
    .load_val (bus_wdata),
    .launch   (launch),
    .sample   (sample),
    .ser_in   (ser_in),
    .shreg    (sh_reg),
    .ser_out  (ser_out),
    .bit_cnt  (sh_cnt),
    .last_bit (last_bit)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        xfer_done <= 1'b0;
    else if (last_bit) xfer_done <= 1'b1;
    else if (data_rd)  xfer_done <= 1'b0;
  end

  assign bus_rdata = bus_sel_data ? sh_reg : cfg;
  assign sck_o     = cfg.enable ? (cfg.cpol ^ (cfg.master & m_phase)) : 1'b1;
  assign sck_oe    = master_on;
  assign mosi_o    = ser_out;
  assign mosi_oe   = master_on;
  assign miso_o    = ser_out;
  assign miso_oe   = slave_go;
  assign ss_o      = ~(master_on & m_busy & ~cfg.ss_ignore);

  AST_DONE_AFTER_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n) $rose(xfer_done) |-> $past(sample)); // R7
  AST_SCK_AT_REST: assert property (@(posedge clk) disable iff (!rst_n) cfg.enable && !m_busy |-> sck_o == cfg.cpol); // R3
  AST_SS_RELEASED: assert property (@(posedge clk) disable iff (!rst_n) !m_busy |-> ss_o); // R8
endmodule

// File: tb/sim_spi_port_top.sv
module sim_spi_port_top;
  localparam int CLK_PERIOD = 10;
  localparam int SHALF = 8;
  localparam int WATCHDOG = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_wr = 1'b0, bus_rd = 1'b0, bus_sel_data = 1'b0;
  logic [7:0] bus_wdata = 8'h00;
  logic [7:0] bus_rdata;
  logic xfer_done, sck_o, sck_oe, mosi_o, mosi_oe, miso_o, miso_oe, ss_o;
  logic sck_drv = 1'b0, mosi_drv = 1'b0, miso_drv = 1'b0, ss_drv = 1'b1;
  logic loop_en = 1'b1;
  logic miso_i;
  int compared = 0, mismatched = 0, cyc = 0;
  bit finished = 0;

  assign miso_i = loop_en ? mosi_o : miso_drv;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_port_top u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_sel_data(bus_sel_data), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xfer_done(xfer_done), .sck_o(sck_o), .sck_oe(sck_oe), .sck_i(sck_drv),
    .mosi_o(mosi_o), .mosi_oe(mosi_oe), .mosi_i(mosi_drv),
    .miso_o(miso_o), .miso_oe(miso_oe), .miso_i(miso_i),
    .ss_o(ss_o), .ss_i(ss_drv)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > WATCHDOG && !finished) begin
      finished = 1;
      compared++;
      mismatched++;
      $display("FAIL watchdog: run hung, actual=%0d expected<=%0d cycles", cyc, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  function automatic int half_of(logic [2:0] c);
    return (c == 3'd7) ? 64 : (1 << c);
  endfunction

  task automatic bus_write(input bit sel, input logic [7:0] d);
    @(negedge clk);
    bus_sel_data = sel;
    bus_wdata = d;
    bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic bus_read(input bit sel, output logic [7:0] d);
    @(negedge clk);
    bus_sel_data = sel;
    bus_rd = 1'b1;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic master_xfer(input logic [2:0] code, input bit cpol, input bit cpha,
                             input bit ign, input logic [7:0] tx);
    logic [7:0] cfgv, cap, rd;
    int half, act, tog, ss_low;
    logic prev;
    half = half_of(code);
    cfgv = {code[2], 1'b1, ign, 1'b1, cpol, cpha, code[1:0]};
    loop_en = 1'b1;
    bus_write(0, 8'h00);
    bus_write(0, cfgv);
    chk("R3 idle sck", sck_o, cpol);
    bus_write(1, tx);
    prev = sck_o; act = 0; tog = 0; ss_low = 0; cap = 8'h00;
    for (int k = 0; k < 16*half + 8; k++) begin
      @(negedge clk);
      if (sck_o != cpol) act++;
      if (!ss_o) ss_low++;
      if (sck_o != prev) begin
        tog++;
        if ((sck_o != cpol) == !cpha) cap = {cap[6:0], mosi_o};
      end
      prev = sck_o;
    end
    chk("R4 sck active cycles", act, 8*half);
    chk("R5 sck edges", tog, 16);
    chk("R6 mosi msb-first at sample edge", cap, tx);
    chk("R7 done set", xfer_done, 1);
    chk("R8 ss_o use", (ss_low > 0), !ign);
    bus_read(1, rd);
    chk("R5 received byte", rd, tx);
    chk("R7 done cleared by read", xfer_done, 0);
  endtask

  task automatic slave_xfer(input bit cpol, input bit cpha, input bit ign, input bit ss_lvl,
                            input logic [7:0] pre, input logic [7:0] tx, input bit ok,
                            input string tag);
    logic [7:0] got, rd;
    bit oe;
    loop_en = 1'b0;
    bus_write(0, 8'h00);
    sck_drv = cpol; ss_drv = 1'b1; mosi_drv = 1'b0;
    repeat (6) @(negedge clk);
    bus_write(0, {1'b0, 1'b1, ign, 1'b0, cpol, cpha, 2'b00});
    bus_write(1, pre);
    ss_drv = ss_lvl;
    repeat (6) @(negedge clk);
    got = 8'h00; oe = 0;
    for (int i = 7; i >= 0; i--) begin
      if (!cpha) begin
        mosi_drv = tx[i];
        repeat (SHALF) @(negedge clk);
        got = {got[6:0], miso_o}; oe |= miso_oe;
        sck_drv = ~cpol;
        repeat (SHALF) @(negedge clk);
        sck_drv = cpol;
      end else begin
        sck_drv = ~cpol;
        mosi_drv = tx[i];
        repeat (SHALF) @(negedge clk);
        got = {got[6:0], miso_o}; oe |= miso_oe;
        sck_drv = cpol;
        repeat (SHALF) @(negedge clk);
      end
    end
    repeat (SHALF) @(negedge clk);
    if (ok) begin
      chk({tag, " slave done"}, xfer_done, 1);
      chk({tag, " R6 miso bits"}, got, pre);
      chk({tag, " miso driven"}, oe, 1);
      bus_read(1, rd);
      chk({tag, " slave received"}, rd, tx);
    end else begin
      chk({tag, " no done when deselected"}, xfer_done, 0);
      chk({tag, " miso released"}, oe, 0);
      bus_read(1, rd);
      chk({tag, " data untouched"}, rd, pre);
    end
    ss_drv = 1'b1;
  endtask

  initial begin
    logic [7:0] rd;
    int tog;
    logic prev;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    bus_read(0, rd);
    chk("R1 ctrl reset", rd, 8'h14);
    chk("R1 sck high", sck_o, 1);
    chk("R1 sck_oe low", sck_oe, 0);
    chk("R1 ss_o high", ss_o, 1);
    chk("R1 done low", xfer_done, 0);

    // R2 disabled
    bus_write(0, 8'h08);
    chk("R2 sck high cpol1 off", sck_o, 1);
    bus_write(0, 8'h00);
    chk("R2 sck high cpol0 off", sck_o, 1);
    bus_write(1, 8'h77);
    prev = sck_o; tog = 0;
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (sck_o != prev) tog++;
      prev = sck_o;
    end
    chk("R2 no edges while off", tog, 0);
    chk("R2 no done while off", xfer_done, 0);

    // R4 rate extremes, then random master bytes
    master_xfer(3'd0, 1'b0, 1'b0, 1'b0, 8'h81);
    master_xfer(3'd7, 1'b1, 1'b1, 1'b1, 8'h5A);
    master_xfer(3'd6, 1'b0, 1'b1, 1'b0, 8'hC3);
    for (int n = 0; n < 8; n++) begin
      logic [2:0] code;
      code = 3'($urandom_range(0, 5));
      master_xfer(code, 1'($urandom()), 1'($urandom()), 1'($urandom()), 8'($urandom()));
    end

    // R11 and R12: writes while a byte is in flight
    loop_en = 1'b1;
    bus_write(0, 8'h00);
    bus_write(0, 8'h52);
    bus_write(1, 8'hA5);
    repeat (3) @(negedge clk);
    bus_write(0, 8'h5D);
    bus_write(1, 8'h3C);
    bus_read(0, rd);
    chk("R11 ctrl held during byte", rd, 8'h52);
    repeat (100) @(negedge clk);
    bus_read(0, rd);
    chk("R11 ctrl applied after byte", rd, 8'h5D);
    chk("R3 new idle level", sck_o, 1);
    bus_read(1, rd);
    chk("R12 data write ignored", rd, 8'hA5);

    // slave role
    for (int n = 0; n < 6; n++) begin
      slave_xfer(1'($urandom()), 1'($urandom()), 1'($urandom()), 1'b0,
                 8'($urandom()), 8'($urandom()), 1'b1, "R6");
    end
    slave_xfer(1'b0, 1'b0, 1'b0, 1'b1, 8'h96, 8'h0F, 1'b0, "R9 cpha0");
    slave_xfer(1'b1, 1'b1, 1'b0, 1'b1, 8'h69, 8'hF0, 1'b0, "R9 cpha1");
    slave_xfer(1'b0, 1'b1, 1'b1, 1'b1, 8'hB4, 8'h2D, 1'b1, "R10 ignore honoured");
    slave_xfer(1'b1, 1'b0, 1'b1, 1'b1, 8'h4B, 8'hD2, 1'b0, "R10 ignore overridden");

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule